// File: doc/BRIEF.md
# Four-Player Quiz Buzzer Controller

This block runs one table of a four-contestant quiz. The host arms a round with a level switch. That starts a thirty-second countdown. The first contestant whose button rises while the round is armed is captured. Their LED lights and their number appears on a single seven-segment digit. The countdown freezes at whatever value it held. The host then uses two score buttons to adjust that contestant's running total. A host clear button ends the round and returns everything to idle except the totals. The totals are cleared only by the chip reset.

Every button and the arm switch enter through a two-flop synchronizer. All buttons are acted on at their rising edge, so one press is one event. The one-second tick comes from a divider whose ratio is a parameter. The block has no streaming data path, so there is no valid/ready interface. Every pin is a plain level control or status signal, and every output can be read at any time without a handshake.

Top module: `quiz_buzzer`

## Requirements
- R1: When the arm input is high and the round is idle, the remaining-time output loads 30. In that state no LED is lit and the segment output is blank (all zeros).
- R2: While the round is running, the remaining time drops by one every TICK_DIV clock cycles. When it reaches 0 with nobody captured, the round locks out: time stays 0, the segment output shows a dash (7'h40, only segment g), and no LED lights.
- R3: The first rising contestant button in a running round is captured. LED bit i lights for player i (bit0 = a, bit3 = d). The segments show the player number 1 to 4, with bit0 = segment a through bit6 = segment g (1 = 7'h06, 2 = 7'h5B, 3 = 7'h4F, 4 = 7'h66). The countdown freezes.
- R4: When several contestant buttons rise in the same cycle, the lowest index wins: a over b over c over d.
- R5: Contestant presses are ignored after a capture, during lockout, and while the arm input is low. Dropping the arm input during a running round returns to idle with the time cleared to 0.
- R6: With a player captured, each rising edge of the add or subtract button changes that player's total by exactly one. Both rising in the same cycle leave the total unchanged.
- R7: Each total is 7 bits wide, saturates at 99 when adding, and stays at 0 when subtracting.
- R8: A host clear press returns to idle and clears the LEDs, segments and time. It leaves every total untouched. Only the active-low chip reset zeroes the totals.
- R9: If a contestant press arrives in the same cycle as the tick that would take the time from 1 to 0, the press wins and the time stays at 1.
- R10: Score buttons have no effect unless a player is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low chip reset; also zeroes totals |
| host_arm | input | 1 | Round enable switch (level) |
| host_clr | input | 1 | Round clear button |
| host_add | input | 1 | Add one to captured player's total |
| host_sub | input | 1 | Subtract one from captured player's total |
| player_btn | input | 4 | Contestant buttons, bit0 = a .. bit3 = d |
| player_led | output | 4 | One-hot LED of the captured player |
| seg | output | 7 | Segment drive, bit0 = a .. bit6 = g, active high |
| secs_left | output | 5 | Remaining seconds |
| totals | output | 28 | Player totals, player p at bits 7p+6:7p |

## Verification
The collision that matters is a contestant press landing in the same cycle as the final countdown tick. The bench polls until the time reads 1. It then drives a button so that its synchronized edge reaches the controller exactly on the edge that consumes the last tick. It then requires a captured player with the time still at 1 and no dash. The add and subtract buttons also collide: both are raised in one cycle and the total must not move. Simultaneous contestant buttons are judged against the fixed priority.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
  localparam int NPLAYER = 4;
  localparam int PIDX_W  = 2;

  typedef enum logic [1:0] {
    RND_IDLE,
    RND_RUN,
    RND_WON,
    RND_LOCK
  } rnd_state_t;

  localparam logic [6:0] SEG_BLANK = 7'h00;
  localparam logic [6:0] SEG_DASH  = 7'h40;

  // bit0 = segment a .. bit6 = segment g
  function automatic logic [6:0] seg_of_player(input logic [PIDX_W-1:0] idx);
    logic [6:0] s;
    case (idx)
      2'd0:    s = 7'h06;
      2'd1:    s = 7'h5B;
      2'd2:    s = 7'h4F;
      default: s = 7'h66;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sync_rise.sv
module sync_rise #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta, stable, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= '0;
      stable <= '0;
      prev   <= '0;
    end else begin
      meta   <= din;
      stable <= meta;
      prev   <= stable;
    end
  end

  assign level = stable;
  assign rise  = stable & ~prev;
endmodule

// File: rtl/tick_div.sv
module tick_div #(
  parameter int DIV = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/round_fsm.sv
module round_fsm
  import quiz_pkg::*;
#(
  parameter int SECS = 30,
  parameter int TW   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                arm,
  input  logic [NPLAYER-1:0]  press,
  input  logic                tick,
  output rnd_state_t          state,
  output logic [PIDX_W-1:0]   win_idx,
  output logic [TW-1:0]       secs
);
  logic [PIDX_W-1:0] first_idx;

  always_comb begin
    first_idx = '0;
    for (int i = NPLAYER - 1; i >= 0; i--)
      if (press[i]) first_idx = PIDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RND_IDLE;
      win_idx <= '0;
      secs    <= '0;
    end else if (clr) begin
      state   <= RND_IDLE;
      win_idx <= '0;
      secs    <= '0;
    end else begin
      case (state)
        RND_IDLE: if (arm) begin
          state <= RND_RUN;
          secs  <= TW'(SECS);
        end
        RND_RUN: begin
          if (!arm) begin
            state <= RND_IDLE;
            secs  <= '0;
          end else if (|press) begin
            state   <= RND_WON;
            win_idx <= first_idx;
          end else if (tick) begin
            secs <= secs - 1'b1;
            if (secs == TW'(1)) state <= RND_LOCK;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/score_bank.sv
module score_bank
  import quiz_pkg::*;
#(
  parameter int SMAX = 99,
  parameter int SW   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [PIDX_W-1:0]    idx,
  input  logic                 inc,
  input  logic                 dec,
  output logic [NPLAYER*SW-1:0] totals
);
  localparam logic [SW-1:0] TOP = SW'(SMAX);

  for (genvar p = 0; p < NPLAYER; p++) begin : g_player
    logic [SW-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '0;
      else if (en && idx == PIDX_W'(p) && (inc ^ dec)) begin
        if (inc && val != TOP)        val <= val + 1'b1;
        else if (dec && val != '0)    val <= val - 1'b1;
      end
    end
    assign totals[p*SW +: SW] = val;
  end
endmodule

// File: rtl/quiz_buzzer.sv
module quiz_buzzer
  import quiz_pkg::*;
#(
  parameter int TICK_DIV = 125_000_000,
  parameter int SECS     = 30,
  parameter int SMAX     = 99,
  parameter int SW       = 7,
  parameter int TW       = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_arm,
  input  logic                  host_clr,
  input  logic                  host_add,
  input  logic                  host_sub,
  input  logic [3:0]            player_btn,
  output logic [3:0]            player_led,
  output logic [6:0]            seg,
  output logic [TW-1:0]         secs_left,
  output logic [NPLAYER*SW-1:0] totals
);
  localparam int NIN = NPLAYER + 4;

  logic [NIN-1:0] lvl, rise;
  logic           tick, clr_rise;
  rnd_state_t     state;
  logic [PIDX_W-1:0] win_idx;

  sync_rise #(.W(NIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({host_arm, host_sub, host_add, host_clr, player_btn}),
    .level (lvl),
    .rise  (rise)
  );

  assign clr_rise = rise[NPLAYER];

  tick_div #(.DIV(TICK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == RND_RUN),
    .tick  (tick)
  );

  round_fsm #(.SECS(SECS), .TW(TW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_rise),
    .arm     (lvl[NPLAYER+3]),
    .press   (rise[NPLAYER-1:0]),
    .tick    (tick),
    .state   (state),
    .win_idx (win_idx),
    .secs    (secs_left)
  );

  score_bank #(.SMAX(SMAX), .SW(SW)) u_score (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (state == RND_WON),
    .idx    (win_idx),
    .inc    (rise[NPLAYER+1]),
    .dec    (rise[NPLAYER+2]),
    .totals (totals)
  );

  always_comb begin
    player_led = '0;
    seg        = SEG_BLANK;
    if (state == RND_WON) begin
      player_led[win_idx] = 1'b1;
      seg                 = seg_of_player(win_idx);
    end else if (state == RND_LOCK) begin
      seg = SEG_DASH;
    end
  end
endmodule

// File: rtl/quiz_buzzer_chk.sv
module quiz_buzzer_chk #(
  parameter int SECS = 30,
  parameter int SMAX = 99,
  parameter int SW   = 7,
  parameter int TW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_rise,
  input logic [3:0]      player_led,
  input logic [6:0]      seg,
  input logic [TW-1:0]   secs_left,
  input logic [4*SW-1:0] totals
);
  assert_led_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(player_led));

  assert_winner_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (player_led != 4'b0) |-> (seg != 7'h00 && seg != 7'h40));

  assert_dash_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == 7'h40) |-> (player_led == 4'b0 && secs_left == '0));

  assert_time_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (secs_left <= $past(secs_left) || secs_left == TW'(SECS)));

  assert_capture_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (player_led != 4'b0 && !clr_rise) |=> (player_led == $past(player_led)));

  for (genvar p = 0; p < 4; p++) begin : g_chk
    assert_total_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      totals[p*SW +: SW] <= SW'(SMAX));

    assert_total_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (totals[p*SW +: SW] == $past(totals[p*SW +: SW]) ||
               totals[p*SW +: SW] == $past(totals[p*SW +: SW]) + 1'b1 ||
               totals[p*SW +: SW] == $past(totals[p*SW +: SW]) - 1'b1));
  end
endmodule

bind quiz_buzzer quiz_buzzer_chk #(
  .SECS(SECS), .SMAX(SMAX), .SW(SW), .TW(TW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_rise   (clr_rise),
  .player_led (player_led),
  .seg        (seg),
  .secs_left  (secs_left),
  .totals     (totals)
);

// File: tb/sim_quiz_buzzer.sv
module sim_quiz_buzzer;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_arm = 1'b0, host_clr = 1'b0, host_add = 1'b0, host_sub = 1'b0;
  logic [3:0]  player_btn = 4'b0;
  logic [3:0]  player_led;
  logic [6:0]  seg;
  logic [4:0]  secs_left;
  logic [27:0] totals;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  quiz_buzzer #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .host_arm(host_arm), .host_clr(host_clr),
    .host_add(host_add), .host_sub(host_sub), .player_btn(player_btn),
    .player_led(player_led), .seg(seg), .secs_left(secs_left), .totals(totals)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int total_of(input int p);
    return int'(totals[p*7 +: 7]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] m);
    player_btn = m; cyc(4); player_btn = 4'b0; cyc(4);
  endtask

  task automatic tap_add(); host_add = 1'b1; cyc(4); host_add = 1'b0; cyc(4); endtask
  task automatic tap_sub(); host_sub = 1'b1; cyc(4); host_sub = 1'b0; cyc(4); endtask

  task automatic end_round();
    host_arm = 1'b0; cyc(2);
    host_clr = 1'b1; cyc(4); host_clr = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    chk("R8 reset led", player_led, 0);
    chk("R8 reset seg", seg, 0);
    chk("R8 reset secs", secs_left, 0);
    chk("R8 reset totals", int'(totals == 28'b0), 1);
  endtask

  task automatic t_disarmed();
    press(4'b0010);
    chk("R5 disarmed press led", player_led, 0);
    tap_add();
    chk("R10 add while idle", int'(totals == 28'b0), 1);
  endtask

  task automatic t_basic_win();
    int held;
    host_arm = 1'b1; cyc(5);
    chk("R1 load secs", secs_left, 30);
    chk("R1 armed led", player_led, 0);
    chk("R1 armed seg", seg, 0);
    press(4'b0100);
    chk("R3 led c", player_led, 4'b0100);
    chk("R3 seg 3", seg, 7'h4F);
    held = secs_left;
    cyc(4 * DIV + 3);
    chk("R3 frozen secs", secs_left, held);
    press(4'b0001);
    chk("R5 late press led", player_led, 4'b0100);
    tap_add(); tap_add();
    chk("R6 add twice", total_of(2), 2);
    tap_sub();
    chk("R6 sub once", total_of(2), 1);
    host_add = 1'b1; host_sub = 1'b1; cyc(4);
    host_add = 1'b0; host_sub = 1'b0; cyc(4);
    chk("R6 add and sub together", total_of(2), 1);
    end_round();
    chk("R8 clr led", player_led, 0);
    chk("R8 clr seg", seg, 0);
    chk("R8 clr secs", secs_left, 0);
    chk("R8 total kept", total_of(2), 1);
  endtask

  task automatic t_priority();
    host_arm = 1'b1; cyc(5);
    press(4'b1110);
    chk("R4 b over c,d led", player_led, 4'b0010);
    chk("R4 b seg 2", seg, 7'h5B);
    end_round();
    host_arm = 1'b1; cyc(5);
    press(4'b1111);
    chk("R4 a wins led", player_led, 4'b0001);
    chk("R4 a seg 1", seg, 7'h06);
    end_round();
  endtask

  task automatic t_lockout();
    int n;
    host_arm = 1'b1; cyc(5);
    while (secs_left != 29) cyc(1);
    n = 0;
    while (secs_left == 29) begin cyc(1); n++; end
    chk("R2 tick period", n, DIV);
    chk("R2 one step", secs_left, 28);
    cyc(30 * DIV + 10);
    chk("R2 lock secs", secs_left, 0);
    chk("R2 lock dash", seg, 7'h40);
    chk("R2 lock led", player_led, 0);
    press(4'b1000);
    chk("R5 lockout press led", player_led, 0);
    tap_add();
    chk("R10 add in lockout", total_of(3), 0);
    end_round();
  endtask

  task automatic t_saturate();
    host_arm = 1'b1; cyc(5);
    press(4'b1000);
    chk("R3 seg 4", seg, 7'h66);
    tap_sub();
    chk("R7 floor 0", total_of(3), 0);
    for (int i = 0; i < 101; i++) tap_add();
    chk("R7 ceiling 99", total_of(3), 99);
    end_round();
    chk("R8 total 99 kept", total_of(3), 99);
  endtask

  task automatic t_last_tick();
    host_arm = 1'b1; cyc(5);
    while (secs_left != 1) cyc(1);
    cyc(1);
    player_btn = 4'b0010;
    cyc(6);
    player_btn = 4'b0;
    chk("R9 press beats final tick led", player_led, 4'b0010);
    chk("R9 secs held", secs_left, 1);
    cyc(3 * DIV);
    chk("R9 still 1", secs_left, 1);
    end_round();
  endtask

  task automatic t_arm_drop();
    host_arm = 1'b1; cyc(5);
    chk("R1 reload", secs_left, 30);
    host_arm = 1'b0; cyc(5);
    chk("R5 arm drop secs", secs_left, 0);
    press(4'b0001);
    chk("R5 arm drop press", player_led, 0);
  endtask

  task automatic t_chip_reset();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    chk("R8 chip reset totals", int'(totals == 28'b0), 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_disarmed();
    t_basic_win();
    t_priority();
    t_lockout();
    t_saturate();
    t_last_tick();
    t_arm_drop();
    t_chip_reset();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule